// File: doc/BRIEF.md
# Audio Automatic Level Control Gain Engine

This block is the control half of an automatic level control for an audio output stage. Each new input-level sample arrives as a signed count of 0.5 dB units measured against a programmable threshold. Positive means the signal is above the threshold. From each sample the block works out a required gain reduction on one of four transfer curves: three soft-knee compression slopes and a hard limiter. It then walks its applied gain-reduction code toward that requirement, one 0.5 dB step at a time.

Steps toward more reduction come at a programmable attack pace. After the target is reached the reduction is held for a fixed period. Only when the input has stayed at or below the threshold for that whole period does the block step the reduction back down, at a programmable release pace. All pacing is counted in pulses of a 1 µs timebase tick. The applied code drives an external gain stage. The three status outputs tell whether the engine is attacking, holding or releasing.

Top module: `alc_gain_ctrl`

## Requirements
- R1: The level input `lvl_db` is signed 8-bit two's complement in 0.5 dB units relative to the threshold; the excess e is `lvl_db` when it is positive and 0 otherwise. With `curve_sel` = 2'b00 the required reduction is floor(e/3).
- R2: With `curve_sel` = 2'b01 the required reduction is floor(e/2). With `curve_sel` = 2'b10 it is e - floor(e/3).
- R3: With `curve_sel` = 2'b11 (limiter) the required reduction equals e. A level at or below the threshold (e = 0) requires no reduction on any curve and starts no attack.
- R4: The required and applied reduction never exceed GR_MAX. A larger curve result is clamped to GR_MAX and the code stops there.
- R5: While the required reduction exceeds the applied code, the code rises by exactly 1 each time ATK_BASE << `atk_code` ticks have been counted. `in_attack` is 1 during this phase.
- R6: During release the code falls by exactly 1 each time REL_BASE << `rel_code` ticks have been counted. When it reaches 0 the engine returns to idle with all status outputs at 0.
- R7: Once the required reduction has been reached, the code is held (`in_hold` = 1) for HOLD_TICKS ticks. The hold count restarts on every cycle in which the stored level is above the threshold. Release begins only after a full count at or below the threshold.
- R8: A stored level whose required reduction exceeds the applied code moves the engine from hold or release back to attack. A stored level above the threshold whose required reduction does not exceed the code moves the engine from release back to hold.
- R9: No step and no progress of any interval happens in a cycle without `tick_us`. An interval paused by missing ticks resumes where it stopped.
- R10: A new level is taken only in a cycle with `lvl_valid` = 1. At other times `lvl_db` has no effect.
- R11: After reset the code is 0 and all status outputs are 0. At most one status output is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse marking each 1 µs of timebase |
| lvl_valid | input | 1 | Marks a new level sample on `lvl_db` |
| lvl_db | input | 8 | Signed level above threshold, 0.5 dB units |
| atk_code | input | 3 | Attack pace code; interval ATK_BASE << code ticks per step |
| rel_code | input | 3 | Release pace code; interval REL_BASE << code ticks per step |
| curve_sel | input | 2 | Transfer curve: 00/01/10 compression, 11 limiter |
| gain_red | output | GR_W | Applied gain reduction, 0.5 dB per unit |
| in_attack | output | 1 | Engine is stepping reduction up |
| in_hold | output | 1 | Engine is holding the reduction |
| in_release | output | 1 | Engine is stepping reduction down |

## Verification
The bench goes after the divide-by-three shift-and-add on both the one-third and the two-thirds curve. Getting it wrong leaves the code settling one step off for excesses that are multiples of three. It checks clamping at the reduction floor: without it the code would climb past GR_MAX under a huge limiter input. Each step interval is counted in ticks, including an attack that is paused by a missing tick; a pacer that counts clocks, or restarts after a pause, shows a wrong interval. The bench times the hold exactly from the last above-threshold sample and drives re-exceedance during release both above and below the applied code. A design that ignored the hold restart, or never fell back to hold or attack, would release early or keep falling.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ATTACK  = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RELEASE = 2'd3
  } alc_state_e;

  // floor(e/3) for 0..255 via (e+1)*85 >> 8, built from shifts and adds
  function automatic logic [7:0] third_of(input logic [7:0] e);
    logic [15:0] t;
    logic [15:0] s;
    t = {8'd0, e} + 16'd1;
    s = (t << 6) + (t << 4) + (t << 2) + t;
    return s[15:8];
  endfunction

  // required reduction for an excess on the selected curve
  function automatic logic [7:0] shape_reduce(input logic [7:0] e, input logic [1:0] sel);
    logic [7:0] r;
    case (sel)
      2'b00:   r = third_of(e);
      2'b01:   r = e >> 1;
      2'b10:   r = e - third_of(e);
      default: r = e;
    endcase
    return r;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/alc_curve.sv
module alc_curve
  import alc_pkg::*;
#(
  parameter int GR_MAX = 80,
  parameter int GR_W   = 7
) (
  input  logic signed [7:0]  level,
  input  logic [1:0]         sel,
  output logic [GR_W-1:0]    target,
  output logic               over_thr
);

  logic [7:0] excess;
  logic [7:0] raw;

  always_comb begin
    over_thr = (level > 8'sd0);
    excess   = over_thr ? level : 8'd0;
    raw      = shape_reduce(excess, sel);
    target   = (raw > 8'(GR_MAX)) ? GR_W'(GR_MAX) : GR_W'(raw);
  end

endmodule

// File: rtl/alc_pacer.sv
module alc_pacer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && tick && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || !run) cnt_q <= '0;
    else if (done)       cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + CNT_W'(1);
  end

  // a missing tick freezes the count unless it is being cleared
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && run) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/alc_seq.sv
module alc_seq
  import alc_pkg::*;
#(
  parameter int GR_W       = 7,
  parameter int CNT_W      = 19,
  parameter int HOLD_TICKS = 105000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [GR_W-1:0]  target,
  input  logic             over_thr,
  input  logic [CNT_W-1:0] atk_lim,
  input  logic [CNT_W-1:0] rel_lim,
  output logic [GR_W-1:0]  gr,
  output alc_state_e       state
);

  localparam logic [GR_W-1:0]  GR_ONE   = GR_W'(1);
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_TICKS);

  alc_state_e      state_q, state_nx;
  logic [GR_W-1:0] gr_q, gr_nx;

  // named events for the assertions
  logic            want_up;
  logic            step_done;
  logic            hold_done;
  logic            step_clr;
  logic            hold_clr;
  logic            step_run;
  logic            hold_run;
  logic [CNT_W-1:0] step_lim;

  assign want_up  = (target > gr_q);
  assign step_run = (state_q == ST_ATTACK) || (state_q == ST_RELEASE);
  assign hold_run = (state_q == ST_HOLD);
  assign step_lim = (state_q == ST_ATTACK) ? atk_lim : rel_lim;

  always_comb begin
    state_nx = state_q;
    gr_nx    = gr_q;
    hold_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (want_up) state_nx = ST_ATTACK;
      end
      ST_ATTACK: begin
        if (!want_up)       state_nx = (gr_q == '0) ? ST_IDLE : ST_HOLD;
        else if (step_done) gr_nx = gr_q + GR_ONE;
      end
      ST_HOLD: begin
        if (want_up)        state_nx = ST_ATTACK;
        else if (over_thr)  hold_clr = 1'b1;
        else if (hold_done) state_nx = ST_RELEASE;
      end
      default: begin
        if (want_up)       state_nx = ST_ATTACK;
        else if (over_thr) state_nx = ST_HOLD;
        else if (step_done) begin
          gr_nx = gr_q - GR_ONE;
          if (gr_q == GR_ONE) state_nx = ST_IDLE;
        end
      end
    endcase
  end

  assign step_clr = (state_nx != state_q);

  alc_pacer #(.CNT_W(CNT_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (step_clr),
    .run   (step_run),
    .tick  (tick),
    .limit (step_lim),
    .done  (step_done)
  );

  alc_pacer #(.CNT_W(CNT_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr || step_clr),
    .run   (hold_run),
    .tick  (tick),
    .limit (HOLD_LIM),
    .done  (hold_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gr_q    <= '0;
    end else begin
      state_q <= state_nx;
      gr_q    <= gr_nx;
    end
  end

  assign gr    = gr_q;
  assign state = state_q;

  p_rise_in_attack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_q > $past(gr_q)) |-> ($past(state_q) == ST_ATTACK));

  p_fall_in_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_q < $past(gr_q)) |-> ($past(state_q) == ST_RELEASE));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_q != $past(gr_q)) |-> ((gr_q == $past(gr_q) + GR_ONE) || (gr_q + GR_ONE == $past(gr_q))));

  p_no_tick_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gr_q));

  p_idle_means_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (gr_q == '0));

  p_release_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_RELEASE) |-> ($past(state_q) == ST_HOLD));

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int GR_MAX     = 80,
  parameter int ATK_BASE   = 32,
  parameter int REL_BASE   = 4000,
  parameter int HOLD_TICKS = 105000,
  localparam int GR_W      = $clog2(GR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_us,
  input  logic                lvl_valid,
  input  logic signed [7:0]   lvl_db,
  input  logic [2:0]          atk_code,
  input  logic [2:0]          rel_code,
  input  logic [1:0]          curve_sel,
  output logic [GR_W-1:0]     gain_red,
  output logic                in_attack,
  output logic                in_hold,
  output logic                in_release
);

  localparam int LONGEST = max3(ATK_BASE << 7, REL_BASE << 7, HOLD_TICKS);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic signed [7:0] lvl_q;
  logic [GR_W-1:0]   target;
  logic              over_thr;
  logic [CNT_W-1:0]  atk_lim;
  logic [CNT_W-1:0]  rel_lim;
  alc_state_e        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lvl_q <= '0;
    else if (lvl_valid) lvl_q <= lvl_db;
  end

  assign atk_lim = CNT_W'(ATK_BASE) << atk_code;
  assign rel_lim = CNT_W'(REL_BASE) << rel_code;

  alc_curve #(.GR_MAX(GR_MAX), .GR_W(GR_W)) u_curve (
    .level    (lvl_q),
    .sel      (curve_sel),
    .target   (target),
    .over_thr (over_thr)
  );

  alc_seq #(.GR_W(GR_W), .CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .target   (target),
    .over_thr (over_thr),
    .atk_lim  (atk_lim),
    .rel_lim  (rel_lim),
    .gr       (gain_red),
    .state    (state)
  );

  assign in_attack  = (state == ST_ATTACK);
  assign in_hold    = (state == ST_HOLD);
  assign in_release = (state == ST_RELEASE);

  p_gain_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_red <= GR_W'(GR_MAX));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_attack, in_hold, in_release}));

  p_quiet_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q <= 8'sd0) |-> (target == '0));

  p_level_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_valid |=> $stable(lvl_q));

endmodule

// File: tb/alc_gain_ctrl_bench.sv
`timescale 1ns/1ps
module alc_gain_ctrl_bench;

  localparam int GR_MAX = 12;
  localparam int ATK_B  = 2;
  localparam int REL_B  = 6;
  localparam int HOLD_T = 30;
  localparam int GR_W   = $clog2(GR_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic lvl_valid = 1'b0;
  logic signed [7:0] lvl_db = '0;
  logic [2:0] atk_code = '0;
  logic [2:0] rel_code = '0;
  logic [1:0] curve_sel = '0;
  logic [GR_W-1:0] gain_red;
  logic in_attack, in_hold, in_release;

  int checks = 0;
  int errors = 0;
  int exp_val[$];
  int exp_ticks[$];
  int tick_seen = 0;
  int prev_gr = 0;

  always #2.5 clk = ~clk;

  alc_gain_ctrl #(.GR_MAX(GR_MAX), .ATK_BASE(ATK_B), .REL_BASE(REL_B), .HOLD_TICKS(HOLD_T))
    u_alc_gain_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .lvl_valid(lvl_valid), .lvl_db(lvl_db),
      .atk_code(atk_code), .rel_code(rel_code), .curve_sel(curve_sel),
      .gain_red(gain_red), .in_attack(in_attack), .in_hold(in_hold), .in_release(in_release));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected reduction, worked out from the curve definitions
  function automatic int exp_target(input int lvl, input int sel);
    int e, r;
    e = (lvl > 0) ? lvl : 0;
    case (sel)
      0: r = e / 3;
      1: r = e / 2;
      2: r = e - e / 3;
      default: r = e;
    endcase
    return (r > GR_MAX) ? GR_MAX : r;
  endfunction

  task automatic push(input int v, input int t);
    exp_val.push_back(v);
    exp_ticks.push_back(t);
  endtask

  // ticks consumed at each rising edge
  always @(posedge clk) if (rst_n && tick_us) tick_seen++;

  // scoreboard monitor: every code change is popped and compared
  always @(negedge clk) begin
    if (rst_n && int'(gain_red) != prev_gr) begin
      if (exp_val.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected step", int'(gain_red), prev_gr);
      end else begin
        int v, t;
        v = exp_val.pop_front();
        t = exp_ticks.pop_front();
        chk(int'(gain_red) == v, "R5/R6 step value", int'(gain_red), v);
        if (t >= 0) chk(tick_seen == t, "R5/R6/R9 step interval", tick_seen, t);
      end
      prev_gr = int'(gain_red);
      tick_seen = 0;
    end
  end

  task automatic send_level(input int v);
    @(negedge clk);
    lvl_valid = 1'b1;
    lvl_db = 8'(v);
    @(negedge clk);
    lvl_valid = 1'b0;
    lvl_db = 8'sd99;
  endtask

  task automatic wait_gr(input int v, input string req);
    int n = 0;
    while (int'(gain_red) != v && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(int'(gain_red) == v, req, int'(gain_red), v);
  endtask

  task automatic wait_hold(input string req);
    int n = 0;
    while (!in_hold && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(in_hold, req, in_hold, 1);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((gain_red != '0 || in_attack || in_hold || in_release) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(gain_red == '0 && !in_attack && !in_hold && !in_release, req,
        int'({in_attack, in_hold, in_release}), 0);
  endtask

  // attack from idle up to the curve target
  task automatic burst(input int lvl, input int sel, input int acode, input string req);
    int tg;
    tg = exp_target(lvl, sel);
    curve_sel = 2'(sel);
    atk_code = 3'(acode);
    for (int i = 1; i <= tg; i++) push(i, (i == 1) ? -1 : (ATK_B << acode));
    send_level(lvl);
    wait_gr(tg, req);
    wait_hold(req);
    chk(int'(gain_red) == tg, req, int'(gain_red), tg);
  endtask

  // release from the current code down to idle
  task automatic release_all(input int from, input int rcode, input string req);
    rel_code = 3'(rcode);
    for (int i = from - 1; i >= 0; i--) push(i, (i == from - 1) ? -1 : (REL_B << rcode));
    send_level(-3);
    wait_idle(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(gain_red == '0, "R11 reset code", int'(gain_red), 0);
    chk({in_attack, in_hold, in_release} == 3'b000, "R11 reset flags",
        int'({in_attack, in_hold, in_release}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: level without valid has no effect
    curve_sel = 2'b11;
    lvl_db = 8'sd50;
    repeat (20) @(negedge clk);
    chk(gain_red == '0 && !in_attack, "R10 level ignored without valid", int'(gain_red), 0);

    // R3: level below threshold starts nothing
    send_level(-10);
    repeat (20) @(negedge clk);
    chk(gain_red == '0 && !in_attack && !in_hold, "R3 below threshold no reduction",
        int'(gain_red), 0);

    // R1 with R5 (attack code 1) and R7 hold timing
    burst(9, 0, 1, "R1 one-third curve");
    repeat (2 * HOLD_T) @(negedge clk);
    chk(in_hold && int'(gain_red) == 3, "R7 hold restarted while above threshold",
        int'(gain_red), 3);
    for (int i = 2; i >= 0; i--) push(i, (i == 2) ? -1 : REL_B);
    rel_code = 3'd0;
    send_level(-4);
    repeat (HOLD_T - 1) @(negedge clk);
    chk(in_hold && !in_release, "R7 still holding one tick before end", int'(in_hold), 1);
    @(negedge clk);
    chk(in_release, "R7 release after full hold", int'(in_release), 1);
    wait_idle("R6 release reaches idle");

    // R2 both compression curves, R6 with release code 1
    burst(11, 1, 0, "R2 half curve");
    release_all(5, 1, "R6 release code 1 to idle");
    burst(10, 2, 0, "R2 two-thirds curve");
    release_all(7, 0, "R6 release code 0 to idle");

    // R3 limiter and R4 floor
    burst(40, 3, 0, "R4 limiter clamped at floor");
    repeat (40) @(negedge clk);
    chk(int'(gain_red) == GR_MAX && in_hold, "R4 no reduction beyond floor",
        int'(gain_red), GR_MAX);
    release_all(GR_MAX, 0, "R6 release from floor");

    // R9 tick gating inside an attack (limiter, code 2)
    curve_sel = 2'b11;
    atk_code = 3'd2;
    for (int i = 1; i <= 4; i++) push(i, (i == 1) ? -1 : (ATK_B << 2));
    send_level(4);
    wait_gr(1, "R3 limiter first step");
    tick_us = 1'b0;
    repeat (50) @(negedge clk);
    chk(int'(gain_red) == 1 && in_attack, "R9 no step without tick", int'(gain_red), 1);
    tick_us = 1'b1;
    wait_gr(4, "R3 limiter target equals excess");
    wait_hold("R7 hold after limiter attack");

    // R8 release back to hold when level is above threshold but target is below code
    rel_code = 3'd0;
    push(3, -1);
    send_level(-2);
    wait_gr(3, "R6 first release step");
    curve_sel = 2'b00;
    send_level(6);
    @(negedge clk);
    chk(in_hold, "R8 release returns to hold", int'(in_hold), 1);
    repeat (15) @(negedge clk);
    chk(int'(gain_red) == 3 && in_hold, "R8 code kept in hold", int'(gain_red), 3);

    // R8 hold back to attack
    curve_sel = 2'b11;
    for (int i = 4; i <= 8; i++) push(i, (i == 4) ? -1 : (ATK_B << 2));
    send_level(8);
    @(negedge clk);
    chk(in_attack, "R8 hold returns to attack", int'(in_attack), 1);
    wait_gr(8, "R8 attack to new target");
    wait_hold("R8 hold at new target");

    // R8 release back to attack
    push(7, -1);
    push(6, REL_B);
    send_level(-2);
    wait_gr(6, "R6 release steps");
    push(7, -1);
    send_level(7);
    @(negedge clk);
    chk(in_attack, "R8 release returns to attack", int'(in_attack), 1);
    wait_gr(7, "R8 re-attack value");
    wait_hold("R8 hold after re-attack");
    release_all(7, 0, "R6 final release to idle");

    repeat (5) @(negedge clk);
    chk(exp_val.size() == 0, "R5/R6 all expected steps seen", exp_val.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule